// File: doc/BRIEF.md
# Host Register Port with Ready Wait States

This block is the slave side of a simple host bus. The bus has separate active-low read and write strobes, an active-low chip select, a 3-bit address, an 8-bit bidirectional data bus and a ready output. Everything is sampled on one system clock. The block decodes host accesses into a bank of eight byte-wide registers.

It stretches every access with wait states. The ready line drops combinationally as soon as chip select and a strobe are both low. It rises again on a fixed clock edge. Reads of address 0 are the internal-access address and take one edge longer than every other access.

An access is not complete until chip select has been seen high on a clock edge. The host can therefore keep a strobe low between accesses and frame each access with chip select alone. A combination of strobes that makes no sense is refused.

The access controller has four named states:

- ST_IDLE: no access is in progress.
- ST_WAIT: ready is held low while the edges are counted.
- ST_DONE: ready is high and the controller waits for chip select to be released.
- ST_BAD: an illegal access with both strobes low.

Transitions:

- From ST_IDLE: a legal request moves to ST_WAIT at edge N. An illegal request moves to ST_BAD.
- From ST_WAIT: the release edge moves to ST_DONE. Chip select high aborts to ST_IDLE. Both strobes low moves to ST_BAD.
- From ST_DONE or ST_BAD: chip select sampled high returns to ST_IDLE.

Top module: `host_port_wait`

## Requirements
- R1: A synchronous reset clears all eight registers to 0x00, drives ready high and returns the controller to ST_IDLE.
- R2: With cs_n low and rd_n low (wr_n high), ready goes low in the same cycle, before any clock edge.
- R3: Edge N is the first rising edge at which the strobe is sampled low. A read of address 0 releases ready on edge N+3. A read of any other address releases it on edge N+2.
- R4: With cs_n low and wr_n low (rd_n high), ready goes low combinationally and is released on edge N+2 for every address.
- R5: A write stores the data bus value into the addressed register on the edge where ready is released. No other register changes.
- R6: The block drives the data bus only while cs_n and rd_n are low and wr_n is high. The driven value is the addressed register, and it is valid when ready rises. At all other times the bus is high impedance.
- R7: After ready is released, the access stays complete while cs_n remains low. Ready stays high and no further write happens, even if the data bus changes.
- R8: An access completes on the edge that samples cs_n high. A new access can begin on the next edge and gets the full wait count.
- R9: cs_n, rd_n and wr_n all low is illegal. No register is written, the bus stays high impedance and ready stays high until cs_n is sampled high.
- R10: If cs_n is sampled high before the release edge, the access is aborted. No register is written and ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address; 0 is the internal-access address |
| data | inout | 8 | Bidirectional data bus |
| rdy | output | 1 | Ready; low while the access is being stretched |

## Verification
Each fault in the controller shows up at the ports within a few edges of the start of an access.

- A wrong edge count or a misread internal-access address moves the rise of ready by at least one edge. The bench counts edges for every address and for both directions.
- A controller stuck in ST_DONE, or leaving it too early, shows as a missing wait on the next back-to-back access or as a second write. A later read then returns the wrong byte.
- A wrong bus enable shows as contention against a host pattern of 0x00 while every register holds a non-zero value.

// File: rtl/host_port_pkg.sv
package host_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2,
        ST_BAD  = 2'd3
    } hp_state_e;

endpackage

// File: rtl/host_port_fsm.sv
module host_port_fsm
    import host_port_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int EXT_WAIT = 2,
    parameter int INT_WAIT = 3,
    parameter int INT_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rdy,
    output logic              wr_en,
    output hp_state_e         state_o
);

    localparam int CNT_W = $clog2(INT_WAIT + 1);

    hp_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             int_rd_q, int_rd_d;
    logic             rd_req, wr_req, bad_req;
    logic [CNT_W-1:0] limit;
    logic             last_edge;

    assign rd_req  = !cs_n && !rd_n && wr_n;
    assign wr_req  = !cs_n && !wr_n && rd_n;
    assign bad_req = !cs_n && !rd_n && !wr_n;

    assign limit     = int_rd_q ? CNT_W'(INT_WAIT) : CNT_W'(EXT_WAIT);
    assign last_edge = (cnt_q + CNT_W'(1)) == limit;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        int_rd_d = int_rd_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bad_req) begin
                    state_d = ST_BAD;
                end else if (rd_req || wr_req) begin
                    state_d  = ST_WAIT;
                    cnt_d    = '0;
                    int_rd_d = rd_req && (addr == ADDR_W'(INT_ADDR));
                end
            end
            ST_WAIT: begin
                if (cs_n) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (bad_req) begin
                    state_d = ST_BAD;
                    cnt_d   = '0;
                end else if (last_edge) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_DONE: if (cs_n) state_d = ST_IDLE;
            ST_BAD:  if (cs_n) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            int_rd_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            int_rd_q <= int_rd_d;
        end
    end

    // outputs
    always_comb begin
        rdy   = 1'b1;
        wr_en = 1'b0;
        unique case (state_q)
            ST_IDLE: rdy = !(rd_req || wr_req);
            ST_WAIT: begin
                rdy   = cs_n;
                wr_en = last_edge && wr_req;
            end
            ST_DONE: rdy = 1'b1;
            ST_BAD:  rdy = 1'b1;
            default: rdy = 1'b1;
        endcase
    end

    assign state_o = state_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> (cnt_q < CNT_W'(INT_WAIT)));                 // R3
    AST_EXT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !int_rd_q && !cs_n && !bad_req &&
         cnt_q == CNT_W'(EXT_WAIT - 1)) |=> (state_q == ST_DONE));            // R4
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE && !cs_n) |=> (state_q == ST_DONE && rdy));       // R7
    AST_BAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BAD && !cs_n) |=> (state_q == ST_BAD && !wr_en));      // R9
    AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cs_n && state_q != ST_IDLE) |=> (state_q == ST_IDLE));               // R8

endmodule

// File: rtl/host_port_regs.sv
module host_port_regs #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NREG = 1 << ADDR_W;

    logic [NREG-1:0][DATA_W-1:0] mem_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(g)) begin
                mem_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem_q));                                           // R5

endmodule

// File: rtl/host_port_wait.sv
module host_port_wait
    import host_port_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int EXT_WAIT = 2,
    parameter int INT_WAIT = 3,
    parameter int INT_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] data,
    output logic              rdy
);

    hp_state_e         fsm_state;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;
    logic              bus_oe;

    host_port_fsm #(
        .ADDR_W  (ADDR_W),
        .EXT_WAIT(EXT_WAIT),
        .INT_WAIT(INT_WAIT),
        .INT_ADDR(INT_ADDR)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .rdy    (rdy),
        .wr_en  (wr_en),
        .state_o(fsm_state)
    );

    host_port_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(addr),
        .wr_data(data),
        .rd_addr(addr),
        .rd_data(rd_data)
    );

    assign bus_oe = !cs_n && !rd_n && wr_n && (fsm_state != ST_BAD);
    assign data   = bus_oe ? rd_data : 'z;

    AST_WRITE_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (fsm_state == ST_WAIT && rd_n));                            // R5
    AST_NO_DRIVE_BAD: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_BAD) |-> !wr_en);                                    // R9
    AST_RDY_IDLE_CS: assert property (@(posedge clk) disable iff (rst)
        (cs_n && fsm_state == ST_IDLE) |-> rdy);                              // R2

endmodule

// File: tb/host_port_wait_tb.sv
`timescale 1ns/1ps
module host_port_wait_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic       host_drv = 1'b0;
    logic [7:0] host_val = '0;
    wire  [7:0] data_bus;
    logic       rdy;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    assign data_bus = host_drv ? host_val : 'z;

    always #2.5 clk = ~clk;

    host_port_wait u_dut (
        .clk (clk), .rst (rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .data(data_bus), .rdy(rdy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // counts rising edges from edge N up to and including the one after which rdy is high
    task automatic count_wait(output int edges);
        edges = 0;
        do begin
            @(posedge clk); #1;
            edges++;
        end while (!rdy && edges < 10);
    endtask

    task automatic do_read(input logic [2:0] a, input logic [7:0] exp_val);
        int e;
        @(negedge clk);
        addr = a; cs_n = 0; rd_n = 0; wr_n = 1;
        #1 chk(rdy == 0, "R2 rdy low before edge", rdy, 0);
        count_wait(e);
        chk(e == ((a == 0) ? 4 : 3), "R3 read release edge", e, (a == 0) ? 4 : 3);
        chk(data_bus == exp_val, "R6 read data", data_bus, exp_val);
        repeat (2) begin
            @(posedge clk); #1;
            chk(rdy == 1, "R7 rdy held after read", rdy, 1);
        end
        @(negedge clk); cs_n = 1; rd_n = 1;
        @(posedge clk);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] v);
        int e;
        @(negedge clk);
        addr = a; host_drv = 1; host_val = v; cs_n = 0; wr_n = 0; rd_n = 1;
        #1 chk(rdy == 0, "R4 rdy low before edge", rdy, 0);
        count_wait(e);
        chk(e == 3, "R4 R8 write release edge", e, 3);
        @(negedge clk); host_val = ~v;
        repeat (2) begin
            @(posedge clk); #1;
            chk(rdy == 1, "R7 rdy held after write", rdy, 1);
        end
        @(negedge clk); cs_n = 1; wr_n = 1; host_drv = 0;
        @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] shadow [8];
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1 chk(rdy == 1, "R1 rdy after reset", rdy, 1);
        for (int a = 0; a < 8; a++) do_read(3'(a), 8'h00);          // R1 cleared registers
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 8; a++) begin
                shadow[a] = 8'((a * 37 + p * 91 + 5) & 255);
                do_write(3'(a), shadow[a]);                         // R5
            end
            for (int a = 0; a < 8; a++) do_read(3'(a), shadow[a]);  // R5 R7 values
        end
        // R6: no drive when cs_n high; host drives 0x00 and must read it back
        @(negedge clk);
        addr = 3'd5; host_drv = 1; host_val = 8'h00; cs_n = 1; rd_n = 0; wr_n = 1;
        #1 chk(data_bus == 8'h00, "R6 bus released with cs high", data_bus, 0);
        // R9: illegal access
        @(negedge clk); cs_n = 0; wr_n = 0;
        #1 chk(rdy == 1, "R9 rdy high on illegal", rdy, 1);
        repeat (4) begin
            @(posedge clk); #1;
            chk(rdy == 1, "R9 rdy stays high", rdy, 1);
            chk(data_bus == 8'h00, "R9 bus undriven", data_bus, 0);
        end
        @(negedge clk); wr_n = 1;
        #1 chk(data_bus == 8'h00, "R9 bus undriven after wr lifts", data_bus, 0);
        @(negedge clk); cs_n = 1; rd_n = 1; host_drv = 0;
        @(posedge clk);
        do_read(3'd5, shadow[5]);                                   // R9 no write
        // R10: abort before release
        @(negedge clk);
        addr = 3'd3; host_drv = 1; host_val = 8'hA5; cs_n = 0; wr_n = 0;
        @(posedge clk);
        @(negedge clk); cs_n = 1; wr_n = 1;
        @(posedge clk); #1;
        chk(rdy == 1, "R10 rdy after abort", rdy, 1);
        @(negedge clk); host_drv = 0;
        do_read(3'd3, shadow[3]);                                   // R10 no write
        // R1: reset mid-life clears registers
        @(negedge clk); rst = 1;
        @(posedge clk);
        @(negedge clk); rst = 0;
        #1 chk(rdy == 1, "R1 rdy after second reset", rdy, 1);
        do_read(3'd6, 8'h00);
        do_read(3'd0, 8'h00);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule